// File: doc/BRIEF.md
# Control Endpoint Setup Capture

This block sits in a USB device controller and captures the 8-byte setup packet that opens every control transfer. It handles a small, parameterised number of control endpoints. Bytes arrive one per strobe from the packet engine, with a marker on the final byte. Each endpoint has its own buffer, which software reads through a small word-addressed register port. A packet is flagged as present only when its final byte lands, so software never acts on a half-written packet.

Software can read a buffer safely in two ways, chosen by a mode bit. In lockout mode, a stored but unacknowledged packet blocks later setups on the same endpoint until software acknowledges it. In tripwire mode, every setup is accepted. Software sets a command bit before it copies the buffer and reads the bit back afterwards. Any stored setup clears that bit, so a zero read back tells software to copy again.

The block also keeps a per-endpoint prime flag and a ready flag. A prime succeeds when the transfer engine acknowledges it: the prime flag falls and the ready flag rises. A setup that lands on a primed endpoint cancels the prime. The prime flag then falls with the ready flag still low, which software reads as a failed prime.

Top module: `ctl_setup_capture`

## Requirements
- R1: After reset, every register reads 0: mode (address 0), command (1), setup flags (2), prime flags (3), ready flags (4) and all buffer words (address 8 and up).
- R2: An accepted packet for endpoint e appears at address 8+2e (bytes 0..3, byte 0 in bits 7:0) and at address 9+2e (bytes 4..7). Setup flag bit e reads 1 from the cycle after the final byte.
- R3: The setup flag for an endpoint does not rise before the cycle that carries the final-byte marker.
- R4: With mode bit 0 at 0 (lockout), a setup whose first byte arrives while the endpoint's setup flag is 1 is ignored. The buffer, the setup flag and the command bit 0 all stay unchanged.
- R5: Writing 1 to a bit of the setup-flag register clears that bit, and writing 0 leaves it unchanged. Clearing the bit releases the lockout for that endpoint.
- R6: With mode bit 0 at 1, a setup always overwrites the buffer, even when the setup flag is already 1. Mode bit 0 reads back as written.
- R7: Command bit 0 (tripwire) reads back as written. Hardware clears it when any endpoint stores a packet.
- R8: Writing 1 to a bit of the prime register sets that prime bit. An acknowledge on a primed endpoint clears its prime bit and sets its ready bit. Writing 1 to a bit of the ready register clears that bit. An acknowledge on an endpoint that is not primed has no effect.
- R9: A packet stored on an endpoint clears that endpoint's prime bit and leaves its ready bit unset.
- R10: When a store lands in the same cycle as another action, the store wins. A software write to the tripwire leaves it 0. A clear of the endpoint's setup flag leaves it 1. An acknowledge on the endpoint leaves prime 0 and ready 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Setup byte strobe |
| pkt_ep | input | EPW | Endpoint of the packet (sampled on the first byte) |
| pkt_byte | input | 8 | Setup byte |
| pkt_last | input | 1 | Marks the final byte |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register word address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| prime_ack | input | NUM_EP | Per-endpoint prime acknowledge from the transfer engine |

## Verification
The bench targets same-cycle collisions between a store and a software write or an acknowledge. A design with the wrong priority would keep a stale tripwire, lose a setup flag, or report a cancelled prime as successful. It checks a repeated setup while the lockout is engaged; a design that ignores the lockout would overwrite the buffer software is reading. It checks that clearing the flag releases the lockout, and that the flag stays low until the final byte, which catches designs that flag packets early or never re-enable capture. It also checks that an acknowledge on an unprimed endpoint is ignored, and that an acknowledge on one endpoint is not disturbed by a store on another.

// File: rtl/ctl_setup_pkg.sv
package ctl_setup_pkg;
   // register word addresses
   localparam int A_MODE  = 0;
   localparam int A_CMD   = 1;
   localparam int A_SFLAG = 2;
   localparam int A_PRIME = 3;
   localparam int A_READY = 4;
   localparam int A_BUF   = 8;

   typedef struct packed {
      logic mode;
      logic cmd;
      logic sflag;
      logic prime;
      logic ready;
   } wr_sel_t;
endpackage

// File: rtl/ctl_setup_rx.sv
module ctl_setup_rx #(
   parameter int NUM_EP    = 2,
   parameter int PKT_BYTES = 8,
   parameter int EPW       = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        pkt_valid,
   input  logic [EPW-1:0]              pkt_ep,
   input  logic [7:0]                  pkt_byte,
   input  logic                        pkt_last,
   input  logic [NUM_EP-1:0]           lock,
   output logic                        commit_vld,
   output logic [EPW-1:0]              commit_ep,
   output logic [NUM_EP*PKT_BYTES*8-1:0] buf_flat
);
   localparam int IDXW = $clog2(PKT_BYTES + 1);
   localparam int EPB  = PKT_BYTES * 8;

   logic [IDXW-1:0] idx_q;
   logic [EPW-1:0]  cur_ep_q;
   logic            cur_acc_q;
   logic            first, ep_ok, sel_acc, wr_en;
   logic [EPW-1:0]  sel_ep;

   always_comb begin
      first   = (idx_q == '0);
      ep_ok   = int'(pkt_ep) < NUM_EP;
      sel_ep  = first ? pkt_ep : cur_ep_q;
      sel_acc = first ? (ep_ok && !lock[pkt_ep]) : cur_acc_q;
      wr_en   = pkt_valid && sel_acc && (idx_q < IDXW'(PKT_BYTES));
   end

   assign commit_vld = pkt_valid && pkt_last && sel_acc;
   assign commit_ep  = sel_ep;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q     <= '0;
         cur_ep_q  <= '0;
         cur_acc_q <= 1'b0;
      end else if (pkt_valid) begin
         if (first) begin
            cur_ep_q  <= pkt_ep;
            cur_acc_q <= sel_acc;
         end
         if (pkt_last)
            idx_q <= '0;
         else if (idx_q < IDXW'(PKT_BYTES))
            idx_q <= idx_q + 1'b1;
      end
   end

   for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
      for (genvar b = 0; b < PKT_BYTES; b++) begin : g_byte
         logic [7:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && sel_ep == EPW'(e) && idx_q == IDXW'(b))
               q <= pkt_byte;
         end
         assign buf_flat[e*EPB + b*8 +: 8] = q;
      end

      // R4: a packet starting on a locked endpoint must not touch its buffer
      p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (lock[e] && pkt_valid && first && pkt_ep == EPW'(e))
            |=> $stable(buf_flat[e*EPB +: EPB]));
   end
endmodule

// File: rtl/ctl_setup_regs.sv
module ctl_setup_regs #(
   parameter int NUM_EP = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  ctl_setup_pkg::wr_sel_t wsel,
   input  logic [NUM_EP-1:0]     wbits,
   input  logic [NUM_EP-1:0]     commit_oh,
   output logic                  mode_q,
   output logic                  tw_q,
   output logic [NUM_EP-1:0]     sflag_q,
   output logic [NUM_EP-1:0]     lock
);
   logic any_commit;
   logic [NUM_EP-1:0] clr_mask;

   assign any_commit = |commit_oh;
   assign clr_mask   = wsel.sflag ? wbits : '0;
   assign lock       = mode_q ? '0 : sflag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= 1'b0;
         tw_q    <= 1'b0;
         sflag_q <= '0;
      end else begin
         if (wsel.mode)
            mode_q <= wbits[0];
         if (any_commit)
            tw_q <= 1'b0;
         else if (wsel.cmd)
            tw_q <= wbits[0];
         sflag_q <= (sflag_q & ~clr_mask) | commit_oh;
      end
   end

   // R7: a stored packet always drops the tripwire
   p_tw_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      any_commit |=> !tw_q);

   for (genvar e = 0; e < NUM_EP; e++) begin : g_chk
      // R3: the flag only rises after a completed store
      p_flag_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(sflag_q[e]) |-> $past(commit_oh[e]));
      // R10: a store beats a same-cycle software clear
      p_store_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
         commit_oh[e] |=> sflag_q[e]);
   end
endmodule

// File: rtl/ctl_setup_prime.sv
module ctl_setup_prime #(
   parameter int NUM_EP = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EP-1:0] set_mask,
   input  logic [NUM_EP-1:0] rdy_clr,
   input  logic [NUM_EP-1:0] ack,
   input  logic [NUM_EP-1:0] cancel,
   output logic [NUM_EP-1:0] prime_q,
   output logic [NUM_EP-1:0] ready_q
);
   for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
      logic done;
      assign done = prime_q[e] && ack[e] && !cancel[e];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prime_q[e] <= 1'b0;
            ready_q[e] <= 1'b0;
         end else begin
            if (cancel[e])
               prime_q[e] <= 1'b0;
            else if (set_mask[e])
               prime_q[e] <= 1'b1;
            else if (done)
               prime_q[e] <= 1'b0;
            if (done)
               ready_q[e] <= 1'b1;
            else if (rdy_clr[e])
               ready_q[e] <= 1'b0;
         end
      end

      // R9: a store cancels the prime without reporting success
      p_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
         cancel[e] |=> (!prime_q[e] && !$rose(ready_q[e])));
      // R8: ready only rises from an acknowledged prime
      p_ready_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ready_q[e]) |-> $past(prime_q[e] && ack[e]));
   end
endmodule

// File: rtl/ctl_setup_capture.sv
module ctl_setup_capture #(
   parameter int NUM_EP    = 2,
   parameter int PKT_BYTES = 8,
   parameter int DW        = 32,
   parameter int RAW       = 4,
   parameter int EPW       = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_valid,
   input  logic [EPW-1:0]    pkt_ep,
   input  logic [7:0]        pkt_byte,
   input  logic              pkt_last,
   input  logic              reg_wr,
   input  logic [RAW-1:0]    reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   input  logic [NUM_EP-1:0] prime_ack
);
   import ctl_setup_pkg::*;

   localparam int WPE   = (PKT_BYTES * 8) / DW;
   localparam int NWORD = NUM_EP * WPE;

   if (NUM_EP < 2 || NUM_EP > DW) begin : g_bad_ep
      $error("NUM_EP out of range");
   end
   if ((PKT_BYTES * 8) % DW != 0) begin : g_bad_dw
      $error("packet size must be a whole number of words");
   end
   if (A_BUF + NWORD > (1 << RAW)) begin : g_bad_raw
      $error("address space too small for buffers");
   end

   wr_sel_t                      wsel;
   logic [NUM_EP-1:0]            wbits;
   logic                         wdata_unused;
   logic                         commit_vld;
   logic [EPW-1:0]               commit_ep;
   logic [NUM_EP-1:0]            commit_oh;
   logic [NUM_EP*PKT_BYTES*8-1:0] buf_flat;
   logic                         mode_q, tw_q;
   logic [NUM_EP-1:0]            sflag_q, lock, prime_q, ready_q;

   assign wbits        = reg_wdata[NUM_EP-1:0];
   assign wdata_unused = ^reg_wdata[DW-1:NUM_EP];

   always_comb begin
      wsel.mode  = reg_wr && reg_addr == RAW'(A_MODE);
      wsel.cmd   = reg_wr && reg_addr == RAW'(A_CMD);
      wsel.sflag = reg_wr && reg_addr == RAW'(A_SFLAG);
      wsel.prime = reg_wr && reg_addr == RAW'(A_PRIME);
      wsel.ready = reg_wr && reg_addr == RAW'(A_READY);
      for (int e = 0; e < NUM_EP; e++)
         commit_oh[e] = commit_vld && commit_ep == EPW'(e);
   end

   ctl_setup_rx #(.NUM_EP(NUM_EP), .PKT_BYTES(PKT_BYTES), .EPW(EPW)) rx_i (
      .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ep(pkt_ep),
      .pkt_byte(pkt_byte), .pkt_last(pkt_last), .lock(lock),
      .commit_vld(commit_vld), .commit_ep(commit_ep), .buf_flat(buf_flat));

   ctl_setup_regs #(.NUM_EP(NUM_EP)) regs_i (
      .clk(clk), .rst_n(rst_n), .wsel(wsel), .wbits(wbits),
      .commit_oh(commit_oh), .mode_q(mode_q), .tw_q(tw_q),
      .sflag_q(sflag_q), .lock(lock));

   ctl_setup_prime #(.NUM_EP(NUM_EP)) prime_i (
      .clk(clk), .rst_n(rst_n),
      .set_mask(wsel.prime ? wbits : '0),
      .rdy_clr(wsel.ready ? wbits : '0),
      .ack(prime_ack), .cancel(commit_oh),
      .prime_q(prime_q), .ready_q(ready_q));

   always_comb begin
      int off;
      reg_rdata = '0;
      off = int'(reg_addr) - A_BUF;
      if (int'(reg_addr) == A_MODE)       reg_rdata[0] = mode_q;
      else if (int'(reg_addr) == A_CMD)   reg_rdata[0] = tw_q;
      else if (int'(reg_addr) == A_SFLAG) reg_rdata[NUM_EP-1:0] = sflag_q;
      else if (int'(reg_addr) == A_PRIME) reg_rdata[NUM_EP-1:0] = prime_q;
      else if (int'(reg_addr) == A_READY) reg_rdata[NUM_EP-1:0] = ready_q;
      else if (off >= 0 && off < NWORD)   reg_rdata = buf_flat[off*DW +: DW];
   end

   // R1: nothing is flagged in the first cycle after reset
   p_reset_clean_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (sflag_q == '0 && prime_q == '0 && ready_q == '0));
endmodule

// File: tb/ctl_setup_capture_tb.sv
module ctl_setup_capture_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NEP = 2;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        pkt_valid = 0;
   logic [0:0]  pkt_ep = '0;
   logic [7:0]  pkt_byte = '0;
   logic        pkt_last = 0;
   logic        reg_wr = 0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [1:0]  prime_ack = '0;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ctl_setup_capture dut_i (
      .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ep(pkt_ep),
      .pkt_byte(pkt_byte), .pkt_last(pkt_last), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .prime_ack(prime_ack));

   // behavioural reference model
   logic [7:0] m_buf [NEP][8];
   bit m_mode, m_tw, m_acc;
   bit [1:0] m_stat, m_prime, m_ready, m_oldp;
   int m_idx, m_ep, cur_ep, commit_ep;
   bit cur_acc, commit;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < NEP; e++)
            for (int b = 0; b < 8; b++) m_buf[e][b] = 0;
         m_mode = 0; m_tw = 0; m_stat = 0; m_prime = 0; m_ready = 0;
         m_idx = 0; m_ep = 0; m_acc = 0;
      end else begin
         commit = 0; commit_ep = -1;
         if (pkt_valid) begin
            if (m_idx == 0) begin
               cur_ep = int'(pkt_ep);
               cur_acc = m_mode || !m_stat[cur_ep];
               m_ep = cur_ep; m_acc = cur_acc;
            end else begin
               cur_ep = m_ep; cur_acc = m_acc;
            end
            if (cur_acc && m_idx < 8) m_buf[cur_ep][m_idx] = pkt_byte;
            if (pkt_last) begin
               commit = cur_acc; commit_ep = cur_ep; m_idx = 0;
            end else if (m_idx < 8) m_idx++;
         end
         m_oldp = m_prime;
         for (int e = 0; e < NEP; e++) begin
            bit cx, st, dn;
            cx = commit && commit_ep == e;
            st = reg_wr && reg_addr == 3 && reg_wdata[e];
            dn = m_oldp[e] && prime_ack[e] && !cx;
            m_prime[e] = cx ? 1'b0 : st ? 1'b1 : dn ? 1'b0 : m_prime[e];
            if (dn) m_ready[e] = 1;
            else if (reg_wr && reg_addr == 4 && reg_wdata[e]) m_ready[e] = 0;
            if (cx) m_stat[e] = 1;
            else if (reg_wr && reg_addr == 2 && reg_wdata[e]) m_stat[e] = 0;
         end
         if (reg_wr && reg_addr == 0) m_mode = reg_wdata[0];
         if (commit) m_tw = 0;
         else if (reg_wr && reg_addr == 1) m_tw = reg_wdata[0];
      end
   end

   function automatic logic [31:0] model_read(int a);
      logic [31:0] r = '0;
      case (a)
         0: r[0] = m_mode;
         1: r[0] = m_tw;
         2: r[1:0] = m_stat;
         3: r[1:0] = m_prime;
         4: r[1:0] = m_ready;
         default:
            if (a >= 8 && a < 12)
               for (int k = 0; k < 4; k++)
                  r[k*8 +: 8] = m_buf[(a-8)/2][((a-8)%2)*4 + k];
      endcase
      return r;
   endfunction

   function automatic string tag_of(int a);
      case (a)
         0: return "R6"; 1: return "R7"; 2: return "R5";
         3: return "R8"; 4: return "R8"; default: return "R2";
      endcase
   endfunction

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [31:0] ex;
         ex = model_read(int'(reg_addr));
         checks++;
         if (reg_rdata !== ex) begin
            fails++;
            $display("FAIL %s model addr=%0d actual=%h expected=%h",
                     tag_of(int'(reg_addr)), reg_addr, reg_rdata, ex);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog actual=%0d expected<20000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic chk(int a, logic [31:0] exp, string tag);
      reg_addr = 4'(a);
      #1;
      checks++;
      if (reg_rdata !== exp) begin
         fails++;
         $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, reg_rdata, exp);
      end
   endtask

   task automatic wreg(int a, logic [31:0] d);
      reg_wr = 1; reg_addr = 4'(a); reg_wdata = d;
      step();
      reg_wr = 0; reg_wdata = '0;
   endtask

   task automatic pulse_ack(logic [1:0] m);
      prime_ack = m; step(); prime_ack = '0;
   endtask

   // mid_exp >= 0: setup-flag value expected just before the final byte (R3)
   task automatic send(int ep, logic [7:0] b0, int mid_exp,
                       bit do_wr, int wa, logic [31:0] wd, logic [1:0] ackm);
      for (int i = 0; i < 8; i++) begin
         if (i == 7 && mid_exp >= 0) chk(2, 32'(mid_exp), "R3");
         pkt_valid = 1; pkt_ep = 1'(ep); pkt_byte = b0 + 8'(i);
         pkt_last = (i == 7);
         if (i == 7) begin
            if (do_wr) begin reg_wr = 1; reg_addr = 4'(wa); reg_wdata = wd; end
            prime_ack = ackm;
         end
         step();
      end
      pkt_valid = 0; pkt_last = 0; reg_wr = 0; reg_wdata = '0; prime_ack = '0;
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1;
      step();
      // R1 reset state
      for (int a = 0; a < 5; a++) chk(a, 0, "R1");
      chk(8, 0, "R1"); chk(11, 0, "R1");

      // R2 / R3 basic capture in lockout mode
      send(0, 8'h11, 0, 0, 0, 0, 0);
      chk(8, 32'h14131211, "R2"); chk(9, 32'h18171615, "R2");
      chk(2, 1, "R2");

      // R4 lockout ignores repeat setup
      wreg(1, 1); chk(1, 1, "R7");
      send(0, 8'h21, -1, 0, 0, 0, 0);
      chk(8, 32'h14131211, "R4"); chk(9, 32'h18171615, "R4");
      chk(2, 1, "R4"); chk(1, 1, "R4");

      // R5 write-one-to-clear and lockout release
      wreg(2, 0); chk(2, 1, "R5");
      wreg(2, 1); chk(2, 0, "R5");
      send(0, 8'h31, 0, 0, 0, 0, 0);
      chk(8, 32'h34333231, "R5"); chk(2, 1, "R5");
      chk(1, 0, "R7");

      // R7 tripwire dropped by a store on the other endpoint
      wreg(1, 1);
      send(1, 8'h51, 1, 0, 0, 0, 0);
      chk(1, 0, "R7"); chk(2, 3, "R2");
      chk(10, 32'h54535251, "R2"); chk(11, 32'h58575655, "R2");

      // R6 lockout disabled: overwrite with flag still set
      wreg(0, 1); chk(0, 1, "R6");
      send(0, 8'h61, -1, 0, 0, 0, 0);
      chk(8, 32'h64636261, "R6"); chk(9, 32'h68676665, "R6");

      // R8 prime success and ready clear
      wreg(3, 1); chk(3, 1, "R8"); chk(4, 0, "R8");
      pulse_ack(2'b01); chk(3, 0, "R8"); chk(4, 1, "R8");
      wreg(4, 1); chk(4, 0, "R8");

      // R9 store cancels prime; stray ack ignored
      wreg(3, 2); chk(3, 2, "R9");
      send(1, 8'h71, -1, 0, 0, 0, 0);
      chk(3, 0, "R9"); chk(4, 0, "R9");
      pulse_ack(2'b10); chk(4, 0, "R8");

      // R10 same-cycle collisions
      wreg(3, 1);
      send(0, 8'h81, -1, 1, 1, 1, 2'b01);
      chk(1, 0, "R10"); chk(3, 0, "R10"); chk(4, 0, "R10");
      send(0, 8'h91, -1, 1, 2, 1, 2'b00);
      chk(2, 3, "R10");

      // R8 ack on ep0 unaffected by a store on ep1
      wreg(3, 1);
      send(1, 8'hA1, -1, 0, 0, 0, 2'b01);
      chk(3, 0, "R8"); chk(4, 1, "R8");

      step();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule